// File: doc/BRIEF.md
# Loop Register Classification Tracker

This block sits beside the issue logic of a core that runs hardware loops. Once the first loop-back branch is taken, it spends exactly one iteration watching which architectural registers are read and which are written. A register that is written after it has already been read in that iteration holds a value that carries from one iteration to the next. The block marks such a register as loop-carried (scalar). All other registers written in the loop are treated as per-iteration (vector) values by the downstream execution units.

A three-state mode machine controls the learning. It moves from normal to learning on the first taken loop branch, and from learning to vector execution on the second. At that point the classification mask is frozen and steers execution until the loop exits. Leaving the loop returns the block to normal and clears all of its learned state. Register R0 is hard-wired and is never classified. A read and a write of the same register in one cycle are ordered read first.

Top module: `loop_cls_tracker`

## Requirements
- R1: After reset, `mode_o` is 0 (normal) and `cls_mask_o` is all zeros.
- R2: The mode is encoded 0 = normal, 1 = learning, 2 = vector. A `loop_taken_i` pulse while the mode is 0 makes `mode_o` read 1 from the next clock.
- R3: While learning, a write to register x (x ≠ 0) sets `cls_mask_o` bit x from the next clock if register x was read in an earlier learning cycle.
- R4: While learning, a write to register x that has not been read since learning began leaves `cls_mask_o` bit x clear.
- R5: A read and a write of the same register in the same learning cycle count as read first, so the write sets that register's classification bit.
- R6: Register R0 is never marked, whatever read and write events occur: `cls_mask_o[0]` stays 0.
- R7: A `loop_taken_i` pulse while learning makes `mode_o` read 2 from the next clock. Events in that final learning cycle still count.
- R8: While the mode is 2, read and write events leave `cls_mask_o` unchanged, and further `loop_taken_i` pulses keep the mode at 2.
- R9: A `loop_exit_i` pulse in any mode clears `mode_o`, `cls_mask_o` and the internal read-seen record on the next clock. Exit takes priority over a simultaneous `loop_taken_i`.
- R10: While the mode is 0, read and write events are ignored. A read made in normal mode does not qualify a later learning-phase write.
- R11: Every read port is observed. A read seen on any of the `NUM_RD` ports qualifies a later write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_vld_i | input | NUM_RD | Read-port valid strobes |
| rd_idx_i | input | NUM_RD*IDX_W | Read-port register indices, one IDX_W field per port |
| wr_vld_i | input | NUM_WR | Write-port valid strobes |
| wr_idx_i | input | NUM_WR*IDX_W | Write-port register indices |
| loop_taken_i | input | 1 | Pulse: loop-back branch taken |
| loop_exit_i | input | 1 | Pulse: loop left |
| mode_o | output | 2 | Current mode (0 normal, 1 learning, 2 vector) |
| cls_mask_o | output | NUM_REGS | Loop-carried classification, one bit per register |

## Verification
The read-seen mask is not visible at the ports, so the hardest behaviour to reach is showing that this hidden record is ignored, cleared or qualified correctly. The stimulus probes it in a later learning iteration. It writes registers that were read in normal mode, in the vector phase, or before an exit, and checks that no classification bit appears. It also writes registers read through each separate read port and checks that the bit does appear. Directed sequences cover same-cycle read/write pairs, R0, and a taken branch arriving in the same cycle as an exit. A long random phase then mixes events with occasional branch and exit pulses against a reference model.

// File: rtl/loop_cls_pkg.sv
package loop_cls_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_LEARN  = 2'd1,
        MODE_VECTOR = 2'd2,
        MODE_RSVD   = 2'd3
    } mode_e;

endpackage

// File: rtl/loop_cls_port_decode.sv
// Turns a set of (valid, index) register-port events into a register mask.
// Bit 0 is always dropped: the zero register never takes part in tracking.
module loop_cls_port_decode #(
    parameter int NUM_REGS  = 32,
    parameter int NUM_PORTS = 2,
    parameter int IDX_W     = $clog2(NUM_REGS)
) (
    input  logic [NUM_PORTS-1:0]            vld_i,
    input  logic [NUM_PORTS-1:0][IDX_W-1:0] idx_i,
    output logic [NUM_REGS-1:0]             hit_o
);

    logic [NUM_PORTS-1:0][NUM_REGS-1:0] port_hit;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        always_comb begin
            port_hit[p] = '0;
            for (int r = 1; r < NUM_REGS; r++) begin
                port_hit[p][r] = vld_i[p] && (idx_i[p] == IDX_W'(r));
            end
        end
    end

    always_comb begin
        hit_o = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            hit_o = hit_o | port_hit[p];
        end
    end

endmodule

// File: rtl/loop_cls_mode_fsm.sv
// Next-mode logic: normal -> learning -> vector, exit back to normal.
module loop_cls_mode_fsm
    import loop_cls_pkg::*;
(
    input  mode_e mode_q_i,
    input  logic  taken_i,
    input  logic  exit_i,
    output mode_e mode_d_o
);

    always_comb begin
        mode_d_o = mode_q_i;
        if (exit_i) begin
            mode_d_o = MODE_NORMAL;
        end else begin
            unique case (mode_q_i)
                MODE_NORMAL: if (taken_i) mode_d_o = MODE_LEARN;
                MODE_LEARN:  if (taken_i) mode_d_o = MODE_VECTOR;
                MODE_VECTOR: mode_d_o = MODE_VECTOR;
                default:     mode_d_o = MODE_NORMAL;
            endcase
        end
    end

endmodule

// File: rtl/loop_cls_tracker.sv
module loop_cls_tracker
    import loop_cls_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int NUM_RD   = 2,
    parameter int NUM_WR   = 1,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic [NUM_RD-1:0]            rd_vld_i,
    input  logic [NUM_RD-1:0][IDX_W-1:0] rd_idx_i,
    input  logic [NUM_WR-1:0]            wr_vld_i,
    input  logic [NUM_WR-1:0][IDX_W-1:0] wr_idx_i,
    input  logic                         loop_taken_i,
    input  logic                         loop_exit_i,
    output logic [1:0]                   mode_o,
    output logic [NUM_REGS-1:0]          cls_mask_o
);

    typedef struct packed {
        mode_e               mode;
        logic [NUM_REGS-1:0] rd_seen;
        logic [NUM_REGS-1:0] cls;
    } trk_state_t;

    trk_state_t          st_d, st_q;
    logic [NUM_REGS-1:0] rd_hit, wr_hit;
    mode_e               mode_d;

    loop_cls_port_decode #(
        .NUM_REGS (NUM_REGS),
        .NUM_PORTS(NUM_RD),
        .IDX_W    (IDX_W)
    ) u_rd_dec (
        .vld_i(rd_vld_i),
        .idx_i(rd_idx_i),
        .hit_o(rd_hit)
    );

    loop_cls_port_decode #(
        .NUM_REGS (NUM_REGS),
        .NUM_PORTS(NUM_WR),
        .IDX_W    (IDX_W)
    ) u_wr_dec (
        .vld_i(wr_vld_i),
        .idx_i(wr_idx_i),
        .hit_o(wr_hit)
    );

    loop_cls_mode_fsm u_mode (
        .mode_q_i(st_q.mode),
        .taken_i (loop_taken_i),
        .exit_i  (loop_exit_i),
        .mode_d_o(mode_d)
    );

    always_comb begin
        st_d      = st_q;
        st_d.mode = mode_d;
        if (loop_exit_i || st_q.mode == MODE_RSVD) begin
            st_d.rd_seen = '0;
            st_d.cls     = '0;
        end else if (st_q.mode == MODE_LEARN) begin
            // same-cycle read counts as earlier than the write
            st_d.rd_seen = st_q.rd_seen | rd_hit;
            st_d.cls     = st_q.cls | (wr_hit & (st_q.rd_seen | rd_hit));
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{mode: MODE_NORMAL, rd_seen: '0, cls: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o     = st_q.mode;
    assign cls_mask_o = st_q.cls;

    // R2: first taken branch starts learning
    a_r2_normal_to_learn: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 2'd0 && loop_taken_i && !loop_exit_i) |=> (mode_o == 2'd1));

    // R7: second taken branch enters vector mode
    a_r7_learn_to_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 2'd1 && loop_taken_i && !loop_exit_i) |=> (mode_o == 2'd2));

    // R8: classification frozen in vector mode
    a_r8_vector_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 2'd2 && !loop_exit_i) |=> ($stable(cls_mask_o) && mode_o == 2'd2));

    // R9: exit clears everything
    a_r9_exit_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        loop_exit_i |=> (mode_o == 2'd0 && cls_mask_o == '0 && st_q.rd_seen == '0));

    // R6: zero register never marked
    a_r6_r0_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cls_mask_o[0]);

    // R3: a classified register must have been read while learning
    a_r3_cls_implies_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cls_mask_o & ~st_q.rd_seen) == '0);

    // R10: nothing accumulates in normal mode
    a_r10_normal_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 2'd0) |-> (cls_mask_o == '0));

endmodule

// File: tb/loop_cls_tracker_tb_top.sv
`timescale 1ns/1ps
module loop_cls_tracker_tb_top;

    localparam int NREG  = 32;
    localparam int NRD   = 2;
    localparam int NWR   = 1;
    localparam int IW    = 5;

    typedef struct {
        logic [1:0]      mode;
        logic [NREG-1:0] cls;
        string           req;
    } exp_t;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [NRD-1:0]           rd_vld = '0;
    logic [NRD-1:0][IW-1:0]   rd_idx = '0;
    logic [NWR-1:0]           wr_vld = '0;
    logic [NWR-1:0][IW-1:0]   wr_idx = '0;
    logic                     taken = 1'b0;
    logic                     ex = 1'b0;
    logic [1:0]               mode;
    logic [NREG-1:0]          cls;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 0;

    // reference model state
    logic [1:0]      m_mode = 2'd0;
    logic [NREG-1:0] m_rd   = '0;
    logic [NREG-1:0] m_cls  = '0;

    always #2 clk = ~clk;

    loop_cls_tracker dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .rd_vld_i    (rd_vld),
        .rd_idx_i    (rd_idx),
        .wr_vld_i    (wr_vld),
        .wr_idx_i    (wr_idx),
        .loop_taken_i(taken),
        .loop_exit_i (ex),
        .mode_o      (mode),
        .cls_mask_o  (cls)
    );

    task automatic check(input logic [1:0] em, input logic [NREG-1:0] ec, input string req);
        n_cmp++;
        if (mode !== em || cls !== ec) begin
            n_bad++;
            $display("FAIL %s: mode=%0d cls=%h expected mode=%0d cls=%h", req, mode, cls, em, ec);
        end
    endtask

    // one cycle of stimulus: drive at negedge, advance model, queue expectation
    task automatic step(input int r0, input int r1, input int w0,
                        input bit tk, input bit xt, input string req);
        logic [NREG-1:0] rh, wh;
        @(negedge clk);
        rd_vld[0] = (r0 >= 0); rd_idx[0] = (r0 >= 0) ? IW'(r0) : '0;
        rd_vld[1] = (r1 >= 0); rd_idx[1] = (r1 >= 0) ? IW'(r1) : '0;
        wr_vld[0] = (w0 >= 0); wr_idx[0] = (w0 >= 0) ? IW'(w0) : '0;
        taken = tk; ex = xt;
        rh = '0; wh = '0;
        if (r0 > 0) rh[r0] = 1'b1;
        if (r1 > 0) rh[r1] = 1'b1;
        if (w0 > 0) wh[w0] = 1'b1;
        if (xt) begin
            m_mode = 2'd0; m_rd = '0; m_cls = '0;
        end else begin
            if (m_mode == 2'd1) begin
                m_cls = m_cls | (wh & (m_rd | rh));
                m_rd  = m_rd | rh;
            end
            if (tk && m_mode == 2'd0) m_mode = 2'd1;
            else if (tk && m_mode == 2'd1) m_mode = 2'd2;
        end
        exp_q.push_back('{mode: m_mode, cls: m_cls, req: req});
    endtask

    // monitor: compare after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.mode, e.cls, e.req);
            end
        end
    end

    initial begin
        #40000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(2'd0, '0, "R1 reset");
        rst_n = 1'b1;

        // R10: events in normal mode ignored; read R5 here must not count later
        step(5, 6, 5, 0, 0, "R10 normal ignore");
        step(7, -1, 7, 0, 0, "R10 normal ignore");
        // R2: enter learning; events in this cycle are still normal-mode
        step(8, -1, 8, 1, 0, "R2 enter learn");
        // R10: write R5 (read only in normal) must not set
        step(-1, -1, 5, 0, 0, "R10 stale read");
        step(-1, -1, 8, 0, 0, "R10 stale read");
        // R3: read R10 then write R10
        step(10, -1, -1, 0, 0, "R3 read");
        step(-1, -1, 10, 0, 0, "R3 read then write");
        // R4: write R11 never read
        step(-1, -1, 11, 0, 0, "R4 write only");
        // R4 then R3: write R12, read R12, write R12
        step(-1, -1, 12, 0, 0, "R4 write first");
        step(12, -1, -1, 0, 0, "R4 read after");
        step(-1, -1, 12, 0, 0, "R3 rewrite after read");
        // R5: same-cycle read and write
        step(13, -1, 13, 0, 0, "R5 same cycle");
        // R11: read via port 1
        step(-1, 14, -1, 0, 0, "R11 port1 read");
        step(-1, -1, 14, 0, 0, "R11 port1 qualifies");
        // R6: R0 read then written
        step(0, 0, -1, 0, 0, "R6 r0 read");
        step(0, -1, 0, 0, 0, "R6 r0 write");
        step(-1, 31, -1, 0, 0, "R3 read top reg");
        // R7: taken while learning, write in that same cycle counts
        step(-1, -1, 31, 1, 0, "R7 enter vector");
        // R8: vector mode frozen
        step(20, -1, 20, 0, 0, "R8 frozen");
        step(-1, -1, 6, 0, 0, "R8 frozen");
        step(-1, -1, -1, 1, 0, "R8 taken stays");
        // R9: exit clears
        step(-1, -1, -1, 0, 1, "R9 exit");
        step(-1, -1, -1, 1, 0, "R2 relearn");
        // R9: read-seen cleared -> R10 (read earlier) write must not set
        step(-1, -1, 10, 0, 0, "R9 rd cleared");
        step(3, -1, 3, 0, 0, "R5 same cycle again");
        // R9: exit wins over taken
        step(-1, -1, -1, 1, 1, "R9 exit priority");
        step(-1, -1, -1, 0, 0, "R9 idle");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            int a, b, c, sel;
            a   = ($urandom % 4 == 0) ? -1 : int'($urandom % NREG);
            b   = ($urandom % 3 == 0) ? -1 : int'($urandom % NREG);
            c   = ($urandom % 3 == 0) ? -1 : int'($urandom % NREG);
            sel = int'($urandom % 40);
            step(a, b, c, sel < 2, sel == 2, "R3 random");
        end
        step(-1, -1, -1, 0, 0, "R9 drain");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule